// File: doc/BRIEF.md
# Half-Bridge Fault Management Controller

This block decides, once per clock, the gate commands for the upper and lower switch of one half-bridge phase. It combines the two logic commands with per-side desaturation requests, the two supply undervoltage flags, a fault-clear input and two shared active-low open-drain lines. One line carries a shutdown/fault signal and the other carries a freeze/sync signal, and several phases are wired together on them. Each open-drain pad is modelled as a pull-down enable output and a sensed input bit. The block ignores a low level on a line while it is pulling that line itself.

A desaturation request starts a timed soft shutdown, during which the sync line is pulled low. When the shutdown ends, the block latches a fault and holds the fault line low until the fault is cleared. A floating-supply undervoltage disables only the upper switch, and the upper switch stays off after recovery until the upper command rises again. Deadtime insertion and desaturation blanking are handled outside this block.

Top module: `hb_fault_ctrl`

## Requirements
- R1: After reset, and again after the logic-supply undervoltage flag falls, both gates stay low for STARTUP_CYC cycles while state_o reads 8. Normal operation follows.
- R2: In normal operation, gate_hi follows hi_in and gate_lo follows lo_in one clock later. state_o reads 1 when either gate is high and 0 otherwise.
- R3: While uv_logic is high, both gates are low and state_o reads 3. This condition takes precedence over every other input, including an external shutdown.
- R4: When the fault line is low and the block is not pulling it, both gates go low and state_o reads 5, whatever hi_in and lo_in are.
- R5: When the sync line is low and the block is not pulling it, both gates hold their present values and state_o reads 6. Changes on hi_in and lo_in have no effect during this time.
- R6: A desat request on either side sets both gates low on the next clock and state_o to 7. It also drives sync_pull high for exactly SSD_CYC cycles. After that, flt_pull goes high, state_o reads 2 and both gates stay low for any hi_in and lo_in. The block's own pull on the fault line is not taken as an external shutdown.
- R7: A latched fault is cleared only by flt_clr high. A clear is ignored while any desat request, uv_logic or uv_float is high. After a clear, flt_pull is released and normal operation resumes.
- R8: While uv_float is high, and no higher-priority condition is present, gate_hi is low, gate_lo follows lo_in and state_o reads 4.
- R9: After uv_float falls, gate_hi stays low even if hi_in stays high. It turns on only after a new rising edge of hi_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_in | input | 1 | Upper switch command |
| lo_in | input | 1 | Lower switch command |
| desat_hi | input | 1 | Upper-side desaturation request |
| desat_lo | input | 1 | Lower-side desaturation request |
| uv_logic | input | 1 | Logic-supply undervoltage flag |
| uv_float | input | 1 | Floating-supply undervoltage flag |
| flt_clr | input | 1 | Fault clear, active high |
| flt_line_in | input | 1 | Sensed level of the shared fault/shutdown line (low = asserted) |
| flt_pull | output | 1 | Pull-down enable for the fault/shutdown line |
| sync_line_in | input | 1 | Sensed level of the shared sync/freeze line (low = asserted) |
| sync_pull | output | 1 | Pull-down enable for the sync/freeze line |
| gate_hi | output | 1 | Upper gate command |
| gate_lo | output | 1 | Lower gate command |
| state_o | output | 4 | State code: 0 off, 1 on, 2 fault, 3 logic UV, 4 floating UV, 5 shutdown, 6 freeze, 7 soft shutdown, 8 start-up |

## Verification
The bench checks the wired-AND loop. A design that reacted to its own fault-line pull would report shutdown (5) in place of fault (2). It also drives uv_logic together with an external shutdown to check that logic undervoltage wins. A wrong priority would show state 5 instead of 3. The bench tries to clear the fault while a desat request or a floating undervoltage is still present; a design that accepted the clear would release the fault line too early. Finally, it holds hi_in high through a floating undervoltage. A design without the re-arm would turn the upper gate on as soon as the undervoltage ended.

// File: rtl/hb_fault_ctrl.sv
module hb_fault_ctrl #(
  parameter int SSD_CYC     = 8,
  parameter int STARTUP_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hi_in,
  input  logic       lo_in,
  input  logic       desat_hi,
  input  logic       desat_lo,
  input  logic       uv_logic,
  input  logic       uv_float,
  input  logic       flt_clr,
  input  logic       flt_line_in,
  output logic       flt_pull,
  input  logic       sync_line_in,
  output logic       sync_pull,
  output logic       gate_hi,
  output logic       gate_lo,
  output logic [3:0] state_o
);
  localparam int MAXC = (SSD_CYC > STARTUP_CYC) ? SSD_CYC : STARTUP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [3:0] {
    S_OFF = 4'd0, S_ON = 4'd1, S_FAULT = 4'd2, S_UVL = 4'd3, S_UVF = 4'd4,
    S_SHUT = 4'd5, S_FRZ = 4'd6, S_SSD = 4'd7, S_START = 4'd8
  } st_t;

  st_t           st, st_n;
  logic [CW-1:0] ssd_cnt, stu_cnt;
  logic          fault_lat, hi_blk, hi_q;
  logic          gh_n, gl_n;

  wire desat   = desat_hi | desat_lo;
  wire ext_sd  = ~flt_line_in & ~fault_lat;
  wire ext_frz = ~sync_line_in & (ssd_cnt == '0);
  wire run     = ~uv_logic & ~ext_sd & ~ext_frz;
  wire hi_rise = hi_in & ~hi_q;
  wire hi_ok   = ~hi_blk | hi_rise;

  assign flt_pull  = fault_lat;
  assign sync_pull = (ssd_cnt != '0);
  assign state_o   = st;

  always_comb begin
    gh_n = 1'b0;
    gl_n = 1'b0;
    st_n = S_OFF;
    if (uv_logic)                                  st_n = S_UVL;
    else if (ext_sd)                               st_n = S_SHUT;
    else if (ext_frz) begin
      st_n = S_FRZ;
      gh_n = gate_hi;
      gl_n = gate_lo;
    end
    else if (stu_cnt != '0)                        st_n = S_START;
    else if (ssd_cnt != '0 || (desat && !fault_lat)) st_n = S_SSD;
    else if (fault_lat)                            st_n = S_FAULT;
    else if (uv_float) begin
      st_n = S_UVF;
      gl_n = lo_in;
    end
    else begin
      gh_n = hi_in & hi_ok;
      gl_n = lo_in;
      st_n = (gh_n | gl_n) ? S_ON : S_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_START;
      gate_hi   <= 1'b0;
      gate_lo   <= 1'b0;
      ssd_cnt   <= '0;
      stu_cnt   <= CW'(STARTUP_CYC);
      fault_lat <= 1'b0;
      hi_blk    <= 1'b0;
      hi_q      <= 1'b0;
    end else begin
      st      <= st_n;
      gate_hi <= gh_n;
      gate_lo <= gl_n;
      hi_q    <= hi_in;

      if (uv_float)     hi_blk <= 1'b1;
      else if (hi_rise) hi_blk <= 1'b0;

      if (uv_logic)                    stu_cnt <= CW'(STARTUP_CYC);
      else if (run && stu_cnt != '0)   stu_cnt <= stu_cnt - 1'b1;

      if (run) begin
        if (ssd_cnt != '0)                              ssd_cnt <= ssd_cnt - 1'b1;
        else if (stu_cnt == '0 && desat && !fault_lat)  ssd_cnt <= CW'(SSD_CYC);
      end

      if (run && ssd_cnt == CW'(1))
        fault_lat <= 1'b1;
      else if (fault_lat && flt_clr && !desat && !uv_logic && !uv_float)
        fault_lat <= 1'b0;
    end
  end
endmodule

module hb_fault_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hi_in,
  input logic       lo_in,
  input logic       desat_hi,
  input logic       desat_lo,
  input logic       uv_logic,
  input logic       uv_float,
  input logic       flt_clr,
  input logic       flt_line_in,
  input logic       flt_pull,
  input logic       sync_line_in,
  input logic       sync_pull,
  input logic       gate_hi,
  input logic       gate_lo,
  input logic [3:0] state_o
);
  p_uvl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    uv_logic |=> (!gate_hi && !gate_lo && state_o == 4'd3));

  p_ext_shut_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_logic && !flt_line_in && !flt_pull) |=> (!gate_hi && !gate_lo));

  p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_logic && flt_line_in && !sync_line_in && !sync_pull)
      |=> ($stable(gate_hi) && $stable(gate_lo)));

  p_fault_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pull |-> (!gate_hi && !gate_lo));

  p_ssd_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pull |-> (!gate_hi && !gate_lo));

  p_clear_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_pull && (desat_hi || desat_lo || uv_float || uv_logic)) |=> flt_pull);

  p_uvf_hi_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_logic && flt_line_in && sync_line_in && uv_float) |=> !gate_hi);
endmodule

bind hb_fault_ctrl hb_fault_ctrl_chk u_chk (.*);

// File: tb/hb_fault_ctrl_tb.sv
`timescale 1ns/1ps
module hb_fault_ctrl_tb;
  localparam int SSD_CYC = 8;
  localparam int STARTUP_CYC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hi_in = 0, lo_in = 0, desat_hi = 0, desat_lo = 0;
  logic uv_logic = 0, uv_float = 0, flt_clr = 0;
  logic ext_flt = 0, ext_sync = 0;
  logic flt_pull, sync_pull, gate_hi, gate_lo;
  logic [3:0] state_o;
  wire flt_line_in  = ~(flt_pull | ext_flt);
  wire sync_line_in = ~(sync_pull | ext_sync);

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hb_fault_ctrl #(.SSD_CYC(SSD_CYC), .STARTUP_CYC(STARTUP_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .hi_in(hi_in), .lo_in(lo_in),
    .desat_hi(desat_hi), .desat_lo(desat_lo), .uv_logic(uv_logic),
    .uv_float(uv_float), .flt_clr(flt_clr), .flt_line_in(flt_line_in),
    .flt_pull(flt_pull), .sync_line_in(sync_line_in), .sync_pull(sync_pull),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .state_o(state_o));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int gh, input int gl, input int st);
    chk(req, "gate_hi", gate_hi, gh);
    chk(req, "gate_lo", gate_lo, gl);
    chk(req, "state", state_o, st);
  endtask

  task automatic t_startup;
    tick(2);
    chk_out("R1", 0, 0, 8);
    rst_n = 1'b1;
    hi_in = 1'b1;
    tick(STARTUP_CYC);
    chk_out("R1", 0, 0, 8);
    tick(1);
    chk_out("R2", 1, 0, 1);
  endtask

  task automatic t_normal;
    hi_in = 0; lo_in = 1;
    tick(1);
    chk_out("R2", 0, 1, 1);
    lo_in = 0;
    tick(1);
    chk_out("R2", 0, 0, 0);
    hi_in = 1;
    tick(1);
  endtask

  task automatic t_uvl;
    uv_logic = 1; ext_flt = 1;
    tick(1);
    chk_out("R3", 0, 0, 3);
    ext_flt = 0;
    tick(1);
    chk_out("R3", 0, 0, 3);
    uv_logic = 0;
    tick(1);
    chk_out("R1", 0, 0, 8);
    tick(STARTUP_CYC - 1);
    chk_out("R1", 0, 0, 8);
    tick(1);
    chk_out("R1", 1, 0, 1);
  endtask

  task automatic t_shut;
    ext_flt = 1; lo_in = 1;
    tick(1);
    chk_out("R4", 0, 0, 5);
    lo_in = 0;
    ext_flt = 0;
    tick(1);
    chk_out("R4", 1, 0, 1);
  endtask

  task automatic t_freeze;
    ext_sync = 1; hi_in = 0; lo_in = 1;
    tick(2);
    chk_out("R5", 1, 0, 6);
    ext_sync = 0;
    tick(1);
    chk_out("R5", 0, 1, 1);
    hi_in = 1; lo_in = 0;
    tick(1);
  endtask

  task automatic t_desat;
    desat_hi = 1;
    tick(1);
    chk_out("R6", 0, 0, 7);
    chk("R6", "sync_pull", sync_pull, 1);
    desat_hi = 0;
    tick(SSD_CYC - 1);
    chk("R6", "sync_pull late", sync_pull, 1);
    chk("R6", "flt_pull early", flt_pull, 0);
    tick(1);
    chk("R6", "sync_pull end", sync_pull, 0);
    chk("R6", "flt_pull", flt_pull, 1);
    tick(1);
    chk_out("R6", 0, 0, 2);
    lo_in = 1;
    tick(2);
    chk_out("R6", 0, 0, 2);
  endtask

  task automatic t_clear;
    desat_lo = 1; flt_clr = 1;
    tick(1);
    flt_clr = 0; desat_lo = 0;
    tick(1);
    chk("R7", "flt_pull after clear with desat", flt_pull, 1);
    uv_float = 1; flt_clr = 1;
    tick(1);
    flt_clr = 0; uv_float = 0;
    tick(1);
    chk("R7", "flt_pull after clear with uv_float", flt_pull, 1);
    chk("R7", "state", state_o, 2);
    hi_in = 0; lo_in = 1; flt_clr = 1;
    tick(1);
    flt_clr = 0;
    chk("R7", "flt_pull released", flt_pull, 0);
    tick(1);
    chk_out("R7", 0, 1, 1);
  endtask

  task automatic t_uvf;
    hi_in = 0;
    tick(1);
    hi_in = 1;
    tick(1);
    chk_out("R2", 1, 1, 1);
    uv_float = 1;
    tick(1);
    chk_out("R8", 0, 1, 4);
    lo_in = 0;
    tick(1);
    chk_out("R8", 0, 0, 4);
    uv_float = 0;
    tick(1);
    chk_out("R9", 0, 0, 0);
    tick(2);
    chk("R9", "gate_hi held", gate_hi, 0);
    hi_in = 0;
    tick(1);
    hi_in = 1;
    tick(1);
    chk_out("R9", 1, 0, 1);
  endtask

  initial begin
    t_startup();
    t_normal();
    t_uvl();
    t_shut();
    t_freeze();
    t_desat();
    t_clear();
    t_uvf();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule